// File: doc/BRIEF.md
# Thread-Filtered Event Performance Counter

This block is a small performance monitoring unit for a multithreaded processor core. It holds a set of general event counters, two by default, plus a free-running active-cycle counter. Each general counter sits in a single 32-bit register that carries three fields: a 4-bit event selector, a per-thread enable mask with one bit for each hardware thread, and a 24-bit running count. The core presents one pulse line for each event code, together with the id of the thread that issued the activity in that cycle. A counter advances by one when the pulse line it selects is high and the issuing thread's mask bit is set. Selector codes listed in a parameter are core-global and count whatever the mask holds.

Software presets a count by writing the register. Loading the two's complement of a sampling period makes the counter wrap after exactly that many events. A wrap from all ones to zero sets a sticky pending flag, and that flag drives the counter's own interrupt line until software clears it through the status register. Writing a zero upper byte while keeping the low 24 bits stops a counter without losing its value. A build-time legacy option models older cores: in that mode there is no overflow interrupt, and any write to a counter register zeroes its count.

Top module: `thread_event_pmu`

## Requirements
- R1: A counter register reads back as selector in bits 31:28, thread mask in bits 27:24 and count in bits 23:0. In normal mode a write stores all 32 bits as written. Word address i (i < NUM_CTR) selects counter i.
- R2: A counter adds exactly one on a clock edge where the pulse input indexed by its selector is high and the mask bit indexed by the event thread id is set. It adds nothing for other codes or other threads, and never more than one per cycle.
- R3: After a write whose upper byte is zero (selector 0, empty mask), the counter holds its count while events arrive.
- R4: Selector codes whose bit is set in GLOBAL_SEL (default codes 14 and 15) count regardless of the mask. Selector 0 honours the mask.
- R5: In normal mode, a count step from 24'hFFFFFF to 0 sets counter i's pending flag. Pending drives ovf_irq[i] and reads as bit 16+i of the status word at address NUM_CTR.
- R6: Writing the status word clears each pending flag whose bit 16+i is 1 and leaves the flags whose bit is 0. A wrap in the same cycle as a clear leaves the flag set.
- R7: When a bus write to a counter and a counted event fall in the same cycle, the register takes the written value.
- R8: With LEGACY=1, ovf_irq stays 0, the status word reads 0, and any counter write loads selector and mask from the data but sets the count to 0.
- R9: The active-cycle counter at address NUM_CTR+1 is 32 bits wide, increments on every clock after reset and ignores writes.
- R10: Synchronous active-high reset clears every counter register, pending flag, the cycle counter and bus_rdata.
- R11: bus_rdata is registered and shows, one clock later, the value the addressed register held before that edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| ev_pulse | input | 16 | One pulse line per event code |
| ev_tid | input | 2 | Thread id of the activity in this cycle |
| ovf_irq | output | NUM_CTR | Pending overflow interrupt, one per counter |

## Verification
The bench goes after the wrap edge, the status clear racing a wrap, and a counter write racing an event. A design that got these wrong would miss or duplicate an interrupt, drop a pending flag, or add one to a value software had just preset. It also exercises selector 0 against a global code with an empty mask, and a stop-by-upper-byte write. A wrong design would count with the mask cleared, or count a global code only for enabled threads. A legacy instance runs beside the normal one under the same stimulus, so a count that survives a write or a stray interrupt in that mode shows up at once. Reads of the cycle counter around a write to it catch a counter that can be preset.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned MASK_W   = 4;
  localparam int unsigned CNT_W    = 24;
  localparam int unsigned NUM_EVT  = 1 << SEL_W;
  localparam int unsigned TID_W    = $clog2(MASK_W);
  localparam int unsigned STAT_LSB = 16;

  // Field order is fixed: software decodes these positions.
  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [MASK_W-1:0] mask;
    logic [CNT_W-1:0]  cnt;
  } ctr_reg_t;
endpackage

// File: rtl/pmu_event_counter.sv
module pmu_event_counter
  import pmu_pkg::*;
#(
  parameter bit                 LEGACY     = 1'b0,
  parameter logic [NUM_EVT-1:0] GLOBAL_SEL = 16'hC000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  input  logic [NUM_EVT-1:0] ev_pulse,
  input  logic [TID_W-1:0]  ev_tid,
  input  logic              pend_clr,
  output ctr_reg_t          reg_q,
  output logic              pend_q
);
  ctr_reg_t wr_fields;
  logic     hit;
  logic     wrap;

  assign wr_fields = ctr_reg_t'(wdata);
  assign hit  = ev_pulse[reg_q.sel] && (GLOBAL_SEL[reg_q.sel] || reg_q.mask[ev_tid]);
  assign wrap = hit && (&reg_q.cnt) && !wr_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q <= '0;
    end else if (wr_en) begin
      reg_q.sel  <= wr_fields.sel;
      reg_q.mask <= wr_fields.mask;
      reg_q.cnt  <= LEGACY ? '0 : wr_fields.cnt;
    end else if (hit) begin
      reg_q.cnt <= reg_q.cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || LEGACY) begin
      pend_q <= 1'b0;
    end else if (wrap) begin
      pend_q <= 1'b1;
    end else if (pend_clr) begin
      pend_q <= 1'b0;
    end
  end

  assert_write_wins_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (reg_q.sel == $past(wr_fields.sel)) && (reg_q.mask == $past(wr_fields.mask)) &&
              (reg_q.cnt == (LEGACY ? CNT_W'(0) : $past(wr_fields.cnt))));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (reg_q.cnt == $past(reg_q.cnt)) || (reg_q.cnt == CNT_W'($past(reg_q.cnt) + 1'b1)));

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !ev_pulse[reg_q.sel]) |=> $stable(reg_q));

  assert_pend_from_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> ($past(&reg_q.cnt) && !$past(wr_en) && (reg_q.cnt == '0)));
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
  parameter int unsigned CYC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CYC_W-1:0] cyc_q
);
  always_ff @(posedge clk) begin
    if (rst) cyc_q <= '0;
    else     cyc_q <= cyc_q + 1'b1;
  end

  assert_cycle_step_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cyc_q == CYC_W'($past(cyc_q) + 1'b1));
endmodule

// File: rtl/thread_event_pmu.sv
module thread_event_pmu
  import pmu_pkg::*;
#(
  parameter int unsigned        NUM_CTR    = 2,
  parameter int unsigned        ADDR_W     = 3,
  parameter int unsigned        CYC_W      = 32,
  parameter bit                 LEGACY     = 1'b0,
  parameter logic [NUM_EVT-1:0] GLOBAL_SEL = 16'hC000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  input  logic [NUM_EVT-1:0] ev_pulse,
  input  logic [TID_W-1:0]   ev_tid,
  output logic [NUM_CTR-1:0] ovf_irq
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_CTR);
  localparam logic [ADDR_W-1:0] CYC_ADDR  = ADDR_W'(NUM_CTR + 1);

  ctr_reg_t           ctr_q [NUM_CTR];
  logic [NUM_CTR-1:0] pend;
  logic [CYC_W-1:0]   cyc_q;
  logic [REG_W-1:0]   stat_word;
  logic [REG_W-1:0]   rd_mux;
  logic               stat_wr;

  assign stat_wr = bus_wr && (bus_addr == STAT_ADDR);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic wr_i;
    assign wr_i = bus_wr && (bus_addr == ADDR_W'(i));
    pmu_event_counter #(
      .LEGACY     (LEGACY),
      .GLOBAL_SEL (GLOBAL_SEL)
    ) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_i),
      .wdata    (bus_wdata),
      .ev_pulse (ev_pulse),
      .ev_tid   (ev_tid),
      .pend_clr (stat_wr && bus_wdata[STAT_LSB + i]),
      .reg_q    (ctr_q[i]),
      .pend_q   (pend[i])
    );
  end

  pmu_cycle_counter #(.CYC_W(CYC_W)) u_cyc (
    .clk   (clk),
    .rst   (rst),
    .cyc_q (cyc_q)
  );

  always_comb begin
    stat_word = '0;
    for (int i = 0; i < NUM_CTR; i++) stat_word[STAT_LSB + i] = pend[i];
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (bus_addr == ADDR_W'(i)) rd_mux = ctr_q[i];
    end
    if (bus_addr == STAT_ADDR) rd_mux = stat_word;
    if (bus_addr == CYC_ADDR)  rd_mux = REG_W'(cyc_q);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assign ovf_irq = pend;

  assert_rdata_reset_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bus_rdata == '0) && (ovf_irq == '0));

  assert_clear_works_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && bus_wdata[STAT_LSB] && !ev_pulse[ctr_q[0].sel]) |=> !ovf_irq[0]);
endmodule

// File: tb/sim_thread_event_pmu.sv
`timescale 1ns/1ps
module sim_thread_event_pmu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] ev_pulse = '0;
  logic [1:0]  ev_tid = '0;
  logic [31:0] rd0, rd1;
  logic [1:0]  irq0, irq1;

  localparam logic [15:0] GSEL = 16'hC000;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  thread_event_pmu #(.LEGACY(1'b0), .GLOBAL_SEL(GSEL)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd0), .ev_pulse(ev_pulse), .ev_tid(ev_tid), .ovf_irq(irq0));

  thread_event_pmu #(.LEGACY(1'b1), .GLOBAL_SEL(GSEL)) u1 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd1), .ev_pulse(ev_pulse), .ev_tid(ev_tid), .ovf_irq(irq1));

  // Behavioural reference: index k=0 normal instance, k=1 legacy instance.
  logic [31:0] m_ctr [2][2];
  logic        m_pend [2][2];
  logic [31:0] m_cyc;
  logic [31:0] m_rd [2];
  logic [2:0]  m_addr;
  bit          cmp_en = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 2; k++) begin
        m_rd[k] = '0;
        for (int c = 0; c < 2; c++) begin m_ctr[k][c] = '0; m_pend[k][c] = 1'b0; end
      end
      m_cyc  = '0;
      cmp_en = 0;
    end else begin
      m_addr = bus_addr;
      for (int k = 0; k < 2; k++) begin
        case (bus_addr)
          3'd0: m_rd[k] = m_ctr[k][0];
          3'd1: m_rd[k] = m_ctr[k][1];
          3'd2: m_rd[k] = {14'b0, m_pend[k][1], m_pend[k][0], 16'b0};
          3'd3: m_rd[k] = m_cyc;
          default: m_rd[k] = '0;
        endcase
        for (int c = 0; c < 2; c++) begin
          logic [3:0] s;
          bit hit, wrp;
          s   = m_ctr[k][c][31:28];
          hit = ev_pulse[s] && (GSEL[s] || m_ctr[k][c][24 + ev_tid]);
          wrp = 0;
          if (bus_wr && bus_addr == 3'(c)) begin
            m_ctr[k][c] = (k == 1) ? {bus_wdata[31:24], 24'h0} : bus_wdata;
          end else if (hit) begin
            if (m_ctr[k][c][23:0] == 24'hFFFFFF) wrp = 1;
            m_ctr[k][c][23:0] = m_ctr[k][c][23:0] + 24'h1;
          end
          if (k == 0) begin
            if (wrp) m_pend[k][c] = 1'b1;
            else if (bus_wr && bus_addr == 3'd2 && bus_wdata[16 + c]) m_pend[k][c] = 1'b0;
          end
        end
      end
      m_cyc  = m_cyc + 1;
      cmp_en = 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      string t;
      case (m_addr)
        3'd0, 3'd1: t = "R1";
        3'd2:       t = "R5";
        3'd3:       t = "R9";
        default:    t = "R11";
      endcase
      chk(rd0, m_rd[0], t);
      chk(rd1, m_rd[1], "R8");
      chk({30'b0, irq0}, {30'b0, m_pend[0][1], m_pend[0][0]}, "R5");
      chk({30'b0, irq1}, 32'h0, "R8");
    end
  end

  // Tasks enter and leave at a falling edge.
  task automatic rd(input logic [2:0] a, output logic [31:0] v0, output logic [31:0] v1);
    bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    v0 = rd0; v1 = rd1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input int code, input logic [1:0] tid);
    ev_pulse = '0; ev_pulse[code] = 1'b1; ev_tid = tid;
    @(negedge clk);
    ev_pulse = '0;
  endtask

  initial begin
    logic [31:0] a0, a1, b0, b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10: everything reads zero straight after reset.
    rd(3'd3, a0, a1); chk(a0, 32'h0, "R10");
    rd(3'd0, a0, a1); chk(a0, 32'h0, "R10");
    rd(3'd2, a0, a1); chk(a0, 32'h0, "R10"); chk({30'b0, irq0}, 32'h0, "R10");

    // R1: field layout and write-back.
    wr(3'd0, 32'h3200_0010);
    rd(3'd0, a0, a1); chk(a0, 32'h3200_0010, "R1"); chk(a1, 32'h3200_0000, "R8");

    // R2: matching code and thread counts; others do not.
    repeat (3) pulse(3, 2'd1);
    pulse(3, 2'd0);
    pulse(5, 2'd1);
    rd(3'd0, a0, a1); chk(a0, 32'h3200_0013, "R2"); chk(a1, 32'h3200_0003, "R8");
    ev_pulse = 16'h0008; ev_tid = 2'd1;
    repeat (4) @(negedge clk);
    ev_pulse = '0;
    rd(3'd0, a0, a1); chk(a0, 32'h3200_0017, "R2");

    // R3: zero upper byte stops the counter and keeps the count.
    wr(3'd0, 32'h0000_0017);
    pulse(0, 2'd0); pulse(0, 2'd3);
    rd(3'd0, a0, a1); chk(a0, 32'h0000_0017, "R3");

    // R4: global code ignores an empty mask; selector 0 obeys the mask.
    wr(3'd1, 32'hF000_0005);
    pulse(15, 2'd2);
    rd(3'd1, a0, a1); chk(a0, 32'hF000_0006, "R4");
    wr(3'd1, 32'h0100_0000);
    pulse(0, 2'd1);
    rd(3'd1, a0, a1); chk(a0, 32'h0100_0000, "R4");
    pulse(0, 2'd0);
    rd(3'd1, a0, a1); chk(a0, 32'h0100_0001, "R4");

    // R5: wrap sets pending, irq line A and status bit 16.
    wr(3'd0, 32'h32FF_FFFE);
    pulse(3, 2'd1);
    chk({30'b0, irq0}, 32'h0, "R5");
    pulse(3, 2'd1);
    chk({30'b0, irq0}, 32'h1, "R5");
    rd(3'd0, a0, a1); chk(a0, 32'h3200_0000, "R5");
    rd(3'd2, a0, a1); chk(a0, 32'h0001_0000, "R5"); chk(a1, 32'h0, "R8");
    chk({30'b0, irq1}, 32'h0, "R8");

    // R6: clear only the flagged bit.
    wr(3'd2, 32'h0002_0000); chk({30'b0, irq0}, 32'h1, "R6");
    wr(3'd2, 32'h0001_0000); chk({30'b0, irq0}, 32'h0, "R6");
    // R6: wrap racing a clear keeps the flag.
    wr(3'd0, 32'h32FF_FFFF);
    ev_pulse = 16'h0008; ev_tid = 2'd1;
    wr(3'd2, 32'h0001_0000);
    ev_pulse = '0;
    chk({30'b0, irq0}, 32'h1, "R6");
    wr(3'd2, 32'h0001_0000); chk({30'b0, irq0}, 32'h0, "R6");

    // R7: write beats a same-cycle event.
    ev_pulse = 16'h0008; ev_tid = 2'd1;
    wr(3'd0, 32'h3200_0100);
    ev_pulse = '0;
    rd(3'd0, a0, a1); chk(a0, 32'h3200_0100, "R7"); chk(a1, 32'h3200_0000, "R8");

    // R9: cycle counter ignores writes.
    rd(3'd3, a0, a1);
    wr(3'd3, 32'h0000_0000);
    rd(3'd3, b0, b1); chk(b0 - a0, 32'd2, "R9"); chk(b1, b0, "R9");

    // R11: unmapped address reads zero.
    rd(3'd5, a0, a1); chk(a0, 32'h0, "R11");

    // Mixed traffic, compared against the model every cycle.
    for (int n = 0; n < 4000; n++) begin
      bus_wr   = ($urandom % 6) == 0;
      bus_addr = 3'($urandom % 6);
      bus_wdata = ($urandom % 2) ? {8'($urandom), 20'hFFFFF, 4'($urandom)} : $urandom;
      ev_pulse = 16'($urandom);
      ev_tid   = 2'($urandom);
      @(negedge clk);
    end
    bus_wr = 1'b0; ev_pulse = '0;
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule